// File: doc/BRIEF.md
# Tick Interrupt Reinjection Controller

This block sits between the terminal-count events of a periodic timer and an interrupt line. Its purpose is to keep ticks from being lost when the consumer of the interrupt is slow to acknowledge. In lossless mode it counts the ticks that have arrived but have not been acknowledged. It then replays them one at a time, one for each acknowledge. In fire-and-forget mode every tick goes straight to the line, whether or not earlier ones were acknowledged.

Every delivery is a one-cycle high pulse on the interrupt output. When an NMI-mode enable is set, each delivery also drives a matching watchdog NMI strobe for broadcast. A resync pulse puts the bookkeeping back to its clean state. The system raises it when the timer is reprogrammed, on reset, and when the interrupt line is unmasked.

The block also clamps the programmed timer period. A periodic period below a configured minimum is raised to that minimum, and a one-shot period is passed through unchanged.

Top module: `tick_reinj`

## Requirements
- R1: After reset, and in the cycle after a resync, the pending count reads 0 and the acknowledged flag is set. The flag being set means the next tick in lossless mode is delivered.
- R2: With `reinjectEn` high, each tick raises `pendingOut` by one in the following cycle. With `reinjectEn` low, ticks leave `pendingOut` unchanged.
- R3: With `reinjectEn` low, every tick is delivered, whatever the state of acknowledgment.
- R4: With `reinjectEn` high, a delivery attempt fires only if the acknowledged flag is set or an acknowledge arrives in the same cycle. A firing clears the flag. An attempt that is refused is dropped, and it stays counted in `pendingOut`.
- R5: An acknowledge lowers `pendingOut` by one if it is nonzero, in either mode. If the count was 2 or more before that acknowledge and `reinjectEn` is high, the acknowledge also requests a replay delivery, and that delivery fires at once.
- R6: An acknowledge that is not used by a same-cycle delivery sets the acknowledged flag.
- R7: `irqOut` rises in the cycle after the event that fires it, and stays high for exactly one cycle. An attempt made while the pulse is high is held for one cycle and then retried.
- R8: `nmiOut` is high together with `irqOut` exactly when `nmiModeEn` was high in the cycle that fired the delivery, and it is never high otherwise.
- R9: `pendingOut` saturates at 2^PEND_W-1 and does not wrap.
- R10: A tick and an acknowledge in the same cycle are both applied to the pending count.
- R11: `periodOut` equals `periodIn`, except that when `periodicIn` is high and `periodIn` is below MIN_PERIOD, it equals MIN_PERIOD.
- R12: A resync takes priority over a tick, an acknowledge and any held attempt in the same cycle. That cycle produces no delivery.

Parameters: PEND_W (default 4), PER_W (default 16) and MIN_PERIOD (default 100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Timer terminal-count event, one cycle |
| ackIn | input | 1 | Interrupt acknowledge from the consumer |
| reinjectEn | input | 1 | 1 = lossless replay, 0 = fire-and-forget |
| resyncIn | input | 1 | Clears pending state, sets acknowledged flag |
| nmiModeEn | input | 1 | Deliveries also drive the NMI strobe |
| periodIn | input | PER_W | Programmed timer period |
| periodicIn | input | 1 | 1 = periodic period, 0 = one-shot |
| irqOut | output | 1 | Interrupt pulse |
| nmiOut | output | 1 | Watchdog NMI strobe |
| pendingOut | output | PEND_W | Unacknowledged tick count |
| periodOut | output | PER_W | Clamped period |

## Verification
Several properties are checked on every cycle:
- the one-cycle shape of the pulse;
- the NMI strobe never appearing without the interrupt;
- the count holding at its ceiling;
- the count clearing after a resync;
- immediate delivery in fire-and-forget mode;
- the period clamp.

Other behaviours depend on history, and only the bench scenarios can show them. These are:
- replay on acknowledge when two or more ticks are outstanding;
- a delivery refused for lack of an acknowledge;
- an attempt held across a busy pulse;
- coincident tick and acknowledge;
- resync overriding same-cycle traffic.

For these the bench compares every cycle against a model built from the requirements.

// File: rtl/tick_reinj_pkg.sv
package tick_reinj_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic clearAll;  // resync: zero count, set acknowledged flag
    logic bumpPend;  // count one more tick
    logic dropPend;  // retire one tick on acknowledge
    logic giveAck;   // acknowledge arrived
    logic takeAck;   // a lossless delivery used the flag
  } strobe_t;

  // Datapath-to-control status
  typedef struct packed {
    logic pendZero;
    logic pendMulti;  // two or more outstanding
    logic pendFull;
    logic ackFlag;
  } status_t;

endpackage

// File: rtl/tick_reinj_dpath.sv
module tick_reinj_dpath
  import tick_reinj_pkg::*;
#(
  parameter int PEND_W     = 4,
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [PER_W-1:0]  periodIn,
  input  logic              periodicIn,
  output status_t           st,
  output logic [PEND_W-1:0] pendingOut,
  output logic [PER_W-1:0]  periodOut
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);
  localparam logic [PER_W-1:0]  MIN_P    = PER_W'(MIN_PERIOD);

  logic [PEND_W-1:0] pendCnt;
  logic [PEND_W-1:0] afterDrop;
  logic [PEND_W-1:0] pendNext;
  logic              ackFlag;

  // Retire first, then add, so a full counter hit by tick+ack stays full
  always_comb begin
    afterDrop = stb.dropPend ? pendCnt - PEND_ONE : pendCnt;
    pendNext  = (stb.bumpPend && afterDrop != PEND_MAX) ? afterDrop + PEND_ONE : afterDrop;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      pendCnt <= '0;
      ackFlag <= 1'b1;
    end else begin
      pendCnt <= pendNext;
      if (stb.takeAck)      ackFlag <= 1'b0;
      else if (stb.giveAck) ackFlag <= 1'b1;
    end
  end

  assign st.pendZero  = (pendCnt == '0);
  assign st.pendMulti = (pendCnt > PEND_ONE);
  assign st.pendFull  = (pendCnt == PEND_MAX);
  assign st.ackFlag   = ackFlag;
  assign pendingOut   = pendCnt;

  // Period clamp, present only when a nonzero minimum is configured
  generate
    if (MIN_PERIOD > 0) begin : g_clamp
      always_comb begin
        if (periodicIn && periodIn < MIN_P) periodOut = MIN_P;
        else                                periodOut = periodIn;
      end
    end else begin : g_noclamp
      assign periodOut = periodIn;
    end
  endgenerate

endmodule

// File: rtl/tick_reinj_ctrl.sv
module tick_reinj_ctrl
  import tick_reinj_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickIn,
  input  logic    ackIn,
  input  logic    reinjectEn,
  input  logic    resyncIn,
  input  logic    nmiModeEn,
  input  status_t st,
  output strobe_t stb,
  output logic    irqOut,
  output logic    nmiOut
);

  logic heldReq;   // attempt deferred while a pulse is high
  logic replayReq;
  logic attempt;
  logic permit;
  logic fire;

  always_comb begin
    replayReq = ackIn && reinjectEn && st.pendMulti;
    attempt   = !resyncIn && (heldReq || tickIn || replayReq);
    permit    = !reinjectEn || st.ackFlag || ackIn;
    fire      = attempt && !irqOut && permit;

    stb.clearAll = resyncIn;
    stb.bumpPend = !resyncIn && tickIn && reinjectEn;
    stb.dropPend = !resyncIn && ackIn && !st.pendZero;
    stb.giveAck  = !resyncIn && ackIn;
    stb.takeAck  = fire && reinjectEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldReq <= 1'b0;
      irqOut  <= 1'b0;
      nmiOut  <= 1'b0;
    end else begin
      heldReq <= attempt && irqOut;
      irqOut  <= fire;
      nmiOut  <= fire && nmiModeEn;
    end
  end

endmodule

// File: rtl/tick_reinj.sv
module tick_reinj
  import tick_reinj_pkg::*;
#(
  parameter int PEND_W     = 4,
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              ackIn,
  input  logic              reinjectEn,
  input  logic              resyncIn,
  input  logic              nmiModeEn,
  input  logic [PER_W-1:0]  periodIn,
  input  logic              periodicIn,
  output logic              irqOut,
  output logic              nmiOut,
  output logic [PEND_W-1:0] pendingOut,
  output logic [PER_W-1:0]  periodOut
);

  strobe_t stb;
  status_t st;

  tick_reinj_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .ackIn      (ackIn),
    .reinjectEn (reinjectEn),
    .resyncIn   (resyncIn),
    .nmiModeEn  (nmiModeEn),
    .st         (st),
    .stb        (stb),
    .irqOut     (irqOut),
    .nmiOut     (nmiOut)
  );

  tick_reinj_dpath #(
    .PEND_W     (PEND_W),
    .PER_W      (PER_W),
    .MIN_PERIOD (MIN_PERIOD)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .periodIn   (periodIn),
    .periodicIn (periodicIn),
    .st         (st),
    .pendingOut (pendingOut),
    .periodOut  (periodOut)
  );

endmodule

// File: rtl/tick_reinj_chk.sv
module tick_reinj_chk #(
  parameter int PEND_W     = 4,
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 100
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickIn,
  input logic              ackIn,
  input logic              reinjectEn,
  input logic              resyncIn,
  input logic [PER_W-1:0]  periodIn,
  input logic              periodicIn,
  input logic              irqOut,
  input logic              nmiOut,
  input logic [PEND_W-1:0] pendingOut,
  input logic [PER_W-1:0]  periodOut
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PER_W-1:0]  MIN_P    = PER_W'(MIN_PERIOD);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut);

  a_r8_nmi_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    nmiOut |-> irqOut);

  a_r1_resync_clears: assert property (@(posedge clk) disable iff (!rstN)
    resyncIn |=> (pendingOut == '0 && !irqOut));

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut == PEND_MAX && tickIn && reinjectEn && !resyncIn) |=> pendingOut == PEND_MAX);

  a_r2_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (reinjectEn && tickIn && !ackIn && !resyncIn && pendingOut != PEND_MAX)
      |=> pendingOut == $past(pendingOut) + PEND_W'(1));

  a_r3_direct_fire: assert property (@(posedge clk) disable iff (!rstN)
    (!reinjectEn && tickIn && !resyncIn && !irqOut) |=> irqOut);

  a_r11_clamp_floor: assert property (@(posedge clk) disable iff (!rstN)
    periodicIn |-> periodOut >= MIN_P);

  a_r11_oneshot_pass: assert property (@(posedge clk) disable iff (!rstN)
    !periodicIn |-> periodOut == periodIn);

endmodule

bind tick_reinj tick_reinj_chk #(
  .PEND_W     (PEND_W),
  .PER_W      (PER_W),
  .MIN_PERIOD (MIN_PERIOD)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickIn     (tickIn),
  .ackIn      (ackIn),
  .reinjectEn (reinjectEn),
  .resyncIn   (resyncIn),
  .periodIn   (periodIn),
  .periodicIn (periodicIn),
  .irqOut     (irqOut),
  .nmiOut     (nmiOut),
  .pendingOut (pendingOut),
  .periodOut  (periodOut)
);

// File: tb/tick_reinj_test.sv
module tick_reinj_test;

  localparam int PEND_W = 4;
  localparam int PER_W  = 16;
  localparam int MINP   = 100;
  localparam int MAXP   = (1 << PEND_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, ackIn = 1'b0, reinjectEn = 1'b1, resyncIn = 1'b0, nmiModeEn = 1'b0;
  logic [PER_W-1:0] periodIn = '0;
  logic periodicIn = 1'b0;
  logic irqOut, nmiOut;
  logic [PEND_W-1:0] pendingOut;
  logic [PER_W-1:0] periodOut;

  always #5 clk = ~clk;

  tick_reinj #(.PEND_W(PEND_W), .PER_W(PER_W), .MIN_PERIOD(MINP)) uut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .ackIn(ackIn), .reinjectEn(reinjectEn),
    .resyncIn(resyncIn), .nmiModeEn(nmiModeEn), .periodIn(periodIn), .periodicIn(periodicIn),
    .irqOut(irqOut), .nmiOut(nmiOut), .pendingOut(pendingOut), .periodOut(periodOut)
  );

  typedef struct {
    logic  irq;
    logic  nmi;
    int    pend;
    string tag;
  } item_t;

  item_t expQ[$];
  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 0;

  // Reference state, from the requirements
  int mPend = 0;
  bit mFlag = 1, mHeld = 0, mIrq = 0, mNmi = 0;

  // Driver: one call = one cycle of stimulus; pushes the expected outcome
  task automatic step(input bit t, input bit a, input bit r, input bit s, input bit n, input string tag);
    bit attempt, permit, fire;
    int p;
    @(negedge clk);
    tickIn = t; ackIn = a; reinjectEn = r; resyncIn = s; nmiModeEn = n;
    if (s) begin
      mPend = 0; mFlag = 1; mHeld = 0; mIrq = 0; mNmi = 0;
    end else begin
      attempt = mHeld || t || (a && r && mPend >= 2);
      permit  = !r || mFlag || a;
      fire    = attempt && !mIrq && permit;
      p = mPend;
      if (a && p > 0) p = p - 1;
      if (t && r && p < MAXP) p = p + 1;
      mPend = p;
      if (fire && r) mFlag = 0;
      else if (a)    mFlag = 1;
      mHeld = attempt && mIrq;
      mIrq  = fire;
      mNmi  = fire && n;
    end
    expQ.push_back('{mIrq, mNmi, mPend, tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, reinjectEn, 0, nmiModeEn, tag);
  endtask

  // Monitor: compares registered outputs shortly after each edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      checkCnt++;
      if (irqOut !== it.irq || nmiOut !== it.nmi || int'(pendingOut) != it.pend) begin
        failCnt++;
        $display("FAIL %s: irq/nmi/pend actual %b/%b/%0d expected %b/%b/%0d",
                 it.tag, irqOut, nmiOut, pendingOut, it.irq, it.nmi, it.pend);
      end
    end
  end

  task automatic chkPeriod(input int pin, input bit per, input int expv);
    @(negedge clk);
    periodIn = PER_W'(pin); periodicIn = per;
    #1;
    checkCnt++;
    if (int'(periodOut) != expv) begin
      failCnt++;
      $display("FAIL R11: period %0d periodic %0b actual %0d expected %0d", pin, per, periodOut, expv);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    checkCnt++;
    if (irqOut !== 1'b0 || nmiOut !== 1'b0 || pendingOut !== '0) begin
      failCnt++;
      $display("FAIL R1: reset irq/nmi/pend actual %b/%b/%0d expected 0/0/0", irqOut, nmiOut, pendingOut);
    end
    @(negedge clk); rstN = 1'b1;

    // R11 clamp
    chkPeriod(50, 1, MINP);
    chkPeriod(200, 1, 200);
    chkPeriod(MINP, 1, MINP);
    chkPeriod(50, 0, 50);
    chkPeriod(0, 0, 0);

    // R1/R4: first tick after reset fires (flag set), second refused
    step(1, 0, 1, 0, 0, "R1 R2 R4 first tick fires");
    idle(2, "R7 pulse ends");
    step(1, 0, 1, 0, 0, "R4 tick without ack dropped");
    idle(2, "R4 idle");
    // R5: ack with two pending replays one
    step(0, 1, 1, 0, 0, "R5 ack replays");
    idle(2, "R5 idle");
    step(0, 1, 1, 0, 0, "R5 R6 last ack no replay");
    idle(1, "R6 idle");
    step(1, 0, 1, 0, 0, "R6 flag set, tick fires");
    idle(2, "R6 idle");

    // R8 NMI strobe
    step(0, 1, 1, 0, 1, "R8 ack");
    step(1, 0, 1, 0, 1, "R8 tick fires with nmi");
    idle(2, "R8 idle");

    // R3 fire-and-forget, back-to-back ticks, R7 hold and retry
    step(0, 0, 0, 1, 0, "R1 resync");
    step(1, 0, 0, 0, 0, "R3 tick fires");
    step(1, 0, 0, 0, 0, "R7 tick during pulse held");
    idle(3, "R7 retried");
    step(1, 0, 0, 0, 0, "R3 tick without ack fires");
    idle(2, "R3 idle");
    step(0, 1, 0, 0, 0, "R5 ack in fire-and-forget");
    idle(1, "R3 idle");

    // R12 resync overrides tick and ack
    step(0, 0, 1, 1, 0, "R12 resync");
    step(1, 0, 1, 0, 0, "R12 tick");
    step(1, 0, 1, 0, 0, "R12 tick");
    step(1, 1, 1, 1, 0, "R12 resync beats tick+ack");
    idle(2, "R12 idle no pulse");

    // R9 saturation and R10 coincident tick+ack
    step(0, 0, 1, 1, 0, "R9 resync");
    for (int i = 0; i < MAXP + 3; i++) step(1, 0, 1, 0, 0, "R9 tick toward ceiling");
    idle(2, "R9 at ceiling");
    step(1, 1, 1, 0, 0, "R10 tick+ack at ceiling");
    idle(2, "R10 idle");
    step(1, 1, 1, 0, 0, "R10 tick+ack again");
    idle(2, "R10 idle");
    for (int i = 0; i < MAXP + 2; i++) begin
      step(0, 1, 1, 0, 0, "R5 drain ack");
      idle(1, "R5 drain idle");
    end
    step(1, 0, 1, 0, 0, "R6 tick after drain");
    idle(3, "R6 idle");

    // R2: reinject off does not count
    step(0, 0, 0, 1, 0, "R2 resync");
    step(1, 0, 0, 0, 0, "R2 uncounted tick");
    idle(3, "R2 idle");

    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk); #3;
    done = 1;
    finishRun();
  end

endmodule